// File: doc/BRIEF.md
# Event Counter Bank with Overflow Control

The block holds four 48-bit event counters. Each counter has its own control register. That register turns the counter on, chooses one strobe from the counter's own group of four event inputs, and allows an interrupt request on overflow. A counter adds at most one per clock edge.

When a counter wraps from all-ones to zero, it sets its bit in a sticky overflow status register, and the OR of that register is driven upward as a summary. A wrap on a counter whose interrupt enable is set raises a one-cycle interrupt request. It does this only if the counter's status bit was clear before the wrap, so a second wrap cannot notify again until software clears the bit. Software clears status bits by writing ones to a separate clear register.

A global freeze input stops every counter in the cycle it is high. Software reaches all state through a write port and an independent, combinational read port.

Top module: `event_ctr_bank`

## Requirements
- R1: While reset is held, all control registers, counter values and status bits read as zero, and ovf_o and pmi_req_o are low.
- R2: Addresses 0 to 3 are the control registers of counters 0 to 3. Bit 0 is the enable, bit 1 is the interrupt enable and bits [3:2] are the event select. Counter i watches evt_i[4*i + select]. Reads return the four stored bits zero-extended.
- R3: Addresses 4 to 7 read counters 0 to 3. On each clock edge a counter rises by exactly one when its enable is set, its selected event is high and freeze_i is low. Otherwise it holds.
- R4: While freeze_i is high at a clock edge, no counter changes, except by a software write.
- R5: A counter that increments from all-ones goes to zero and sets status bit i (address 8, bits [3:0]). Status bits are sticky. ovf_o is high whenever any status bit is set.
- R6: pmi_req_o is high for exactly the cycle after an edge at which a counter with its interrupt enable set wraps while its status bit was clear. A wrap with the status bit already set gives no pulse.
- R7: Writing address 9 clears every status bit whose data bit is one and leaves the bits written as zero. Address 9 reads as zero.
- R8: A software write to a counter in a cycle where it would also increment loads the written value and does not set overflow.
- R9: If a counter wraps in the same cycle that its status bit is written to clear, the bit stays set.
- R10: Writes to address 8 have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Event strobes, four per counter |
| freeze_i | input | 1 | Global freeze from the upper controller |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 48 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 48 | Combinational read data |
| ovf_o | output | 1 | Overflow summary (OR of status) |
| pmi_req_o | output | 1 | One-cycle interrupt request |

## Verification
A wrong counter value or a wrong event select shows up on the read port one clock after the edge that caused it. Every address is read back each cycle, so an extra increment, a missed increment or a counted event during freeze is caught within a single cycle. A wrong sticky bit appears at once on ovf_o and on the status read. A faulty notification gate shows up as pmi_req_o being high or low in the one cycle that follows the wrap. Counters are preloaded near all-ones so that wraps, including a wrap that coincides with a clear, happen within a few cycles.

// File: rtl/ecb_pkg.sv
`timescale 1ns/1ps
package ecb_pkg;
  localparam int NUM_CTR     = 4;
  localparam int CTR_W       = 48;
  localparam int EVT_PER_CTR = 4;
  localparam int SEL_W       = $clog2(EVT_PER_CTR);
  localparam int CTL_W       = SEL_W + 2;
  localparam int ADDR_W      = $clog2(2 * NUM_CTR + 2);
  localparam int STAT_ADDR   = 2 * NUM_CTR;
  localparam int OVFC_ADDR   = 2 * NUM_CTR + 1;

  // Control layout: bit0 enable, bit1 interrupt enable, upper bits select.
  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             pmi_en;
    logic             en;
  } ctl_t;
endpackage

// File: rtl/ecb_counter.sv
`timescale 1ns/1ps
module ecb_counter
  import ecb_pkg::*;
#(
  parameter int W   = CTR_W,
  parameter int EVN = EVT_PER_CTR
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVN-1:0] evt_i,
  input  logic           freeze_i,
  input  logic           ctl_we_i,
  input  logic           cnt_we_i,
  input  logic [W-1:0]   wdata_i,
  output ctl_t           ctl_o,
  output logic [W-1:0]   cnt_o,
  output logic           inc_o,
  output logic           wrap_o
);
  ctl_t         ctl_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic         carry;
  logic         hit;

  function automatic logic [W:0] bump(input logic [W-1:0] v);
    return {1'b0, v} + {{W{1'b0}}, 1'b1};
  endfunction

  assign hit            = evt_i[ctl_q.sel];
  assign inc_o          = ctl_q.en & hit & ~freeze_i;
  assign {carry, cnt_nxt} = bump(cnt_q);
  assign wrap_o         = inc_o & carry & ~cnt_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ctl_we_i) ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
      if (cnt_we_i)   cnt_q <= wdata_i;
      else if (inc_o) cnt_q <= cnt_nxt;
    end
  end

  assign ctl_o = ctl_q;
  assign cnt_o = cnt_q;

  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !cnt_we_i) |=> $stable(cnt_q));
  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  // R8
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/ecb_ovf.sv
`timescale 1ns/1ps
module ecb_ovf
  import ecb_pkg::*;
#(
  parameter int N = NUM_CTR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wrap_i,
  input  logic [N-1:0] pmi_en_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] status_o,
  output logic         ovf_o,
  output logic         pmi_req_o
);
  logic [N-1:0] status_q;
  logic [N-1:0] clr_bits;
  logic [N-1:0] fresh;
  logic         pmi_q;

  assign clr_bits = clr_we_i ? clr_mask_i : '0;
  assign fresh    = wrap_i & ~status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      pmi_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_bits) | wrap_i;
      pmi_q    <= |(fresh & pmi_en_i);
    end
  end

  assign status_o  = status_q;
  assign ovf_o     = |status_q;
  assign pmi_req_o = pmi_q;

  // R5 and R9
  wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_i) |=> ((status_q & $past(wrap_i)) == $past(wrap_i)));
  // R7
  clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && wrap_i == '0) |=> ((status_q & $past(clr_mask_i)) == '0));
  // R6
  pmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmi_req_o |-> (status_q != '0));
  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we_i) |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/ecb_rdmux.sv
`timescale 1ns/1ps
module ecb_rdmux
  import ecb_pkg::*;
#(
  parameter int N  = NUM_CTR,
  parameter int W  = CTR_W,
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0]             rd_addr_i,
  input  logic [N-1:0][CTL_W-1:0]   ctl_i,
  input  logic [N-1:0][W-1:0]       cnt_i,
  input  logic [N-1:0]              status_i,
  output logic [W-1:0]              rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_addr_i == AW'(i))     rd_data_o = W'(ctl_i[i]);
      if (rd_addr_i == AW'(N + i)) rd_data_o = cnt_i[i];
    end
    if (rd_addr_i == AW'(2 * N)) rd_data_o = W'(status_i);
  end
endmodule

// File: rtl/event_ctr_bank.sv
`timescale 1ns/1ps
module event_ctr_bank
  import ecb_pkg::*;
#(
  parameter int N   = NUM_CTR,
  parameter int W   = CTR_W,
  parameter int EVN = EVT_PER_CTR,
  parameter int AW  = ADDR_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*EVN-1:0] evt_i,
  input  logic           freeze_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [W-1:0]   wr_data_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [W-1:0]   rd_data_o,
  output logic           ovf_o,
  output logic           pmi_req_o
);
  localparam int CLR_ADDR = 2 * N + 1;

  logic [N-1:0][CTL_W-1:0] ctl_bus;
  logic [N-1:0][W-1:0]     cnt_bus;
  logic [N-1:0]            wrap_vec;
  logic [N-1:0]            inc_vec;
  logic [N-1:0]            pmi_en_vec;
  logic [N-1:0]            status_vec;
  logic                    clr_we;

  assign clr_we = wr_en_i && (wr_addr_i == AW'(CLR_ADDR));

  for (genvar g = 0; g < N; g++) begin : g_ctr
    ctl_t ctl_w;
    logic ctl_we;
    logic cnt_we;
    assign ctl_we = wr_en_i && (wr_addr_i == AW'(g));
    assign cnt_we = wr_en_i && (wr_addr_i == AW'(N + g));

    ecb_counter #(.W(W), .EVN(EVN)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i[g*EVN +: EVN]),
      .freeze_i (freeze_i),
      .ctl_we_i (ctl_we),
      .cnt_we_i (cnt_we),
      .wdata_i  (wr_data_i),
      .ctl_o    (ctl_w),
      .cnt_o    (cnt_bus[g]),
      .inc_o    (inc_vec[g]),
      .wrap_o   (wrap_vec[g])
    );
    assign ctl_bus[g]    = ctl_w;
    assign pmi_en_vec[g] = ctl_w.pmi_en;
  end

  ecb_ovf #(.N(N)) u_ovf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrap_i     (wrap_vec),
    .pmi_en_i   (pmi_en_vec),
    .clr_we_i   (clr_we),
    .clr_mask_i (wr_data_i[N-1:0]),
    .status_o   (status_vec),
    .ovf_o      (ovf_o),
    .pmi_req_o  (pmi_req_o)
  );

  ecb_rdmux #(.N(N), .W(W), .AW(AW)) u_rd (
    .rd_addr_i (rd_addr_i),
    .ctl_i     (ctl_bus),
    .cnt_i     (cnt_bus),
    .status_i  (status_vec),
    .rd_data_o (rd_data_o)
  );

  // R4
  no_inc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |-> (inc_vec == '0));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!ovf_o && !pmi_req_o));
endmodule

// File: tb/event_ctr_bank_bench.sv
`timescale 1ns/1ps
module event_ctr_bank_bench;
  localparam int N = 4;
  localparam int W = 48;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   evt;
  logic          frz;
  logic          we;
  logic [3:0]    wa;
  logic [W-1:0]  wd;
  logic [3:0]    ra;
  logic [W-1:0]  rd;
  logic          ovf, pmi;

  always #4 clk = ~clk;

  event_ctr_bank u_event_ctr_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .freeze_i(frz),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .rd_data_o(rd), .ovf_o(ovf), .pmi_req_o(pmi)
  );

  logic [3:0]   m_ctl [N];
  logic [W-1:0] m_cnt [N];
  logic [N-1:0] m_st;
  logic         m_pmi;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [N-1:0] wr_bits;
    logic [N-1:0] old_st;
    logic [3:0]   nctl [N];
    logic [W-1:0] ncnt [N];
    wr_bits = '0;
    old_st  = m_st;
    for (int i = 0; i < N; i++) begin
      bit go;
      bit cw;
      nctl[i] = m_ctl[i];
      ncnt[i] = m_cnt[i];
      cw = we && (wa == 4'(N + i));
      go = m_ctl[i][0] && evt[i*4 + m_ctl[i][3:2]] && !frz;
      if (cw) ncnt[i] = wd;
      else if (go) begin
        if (m_cnt[i] == ALL1) begin
          ncnt[i] = '0;
          wr_bits[i] = 1'b1;
        end else ncnt[i] = m_cnt[i] + 48'd1;
      end
      if (we && wa == 4'(i)) nctl[i] = wd[3:0];
    end
    m_pmi = 1'b0;
    for (int i = 0; i < N; i++)
      if (wr_bits[i] && m_ctl[i][1] && !old_st[i]) m_pmi = 1'b1;
    if (we && wa == 4'd9) m_st = m_st & ~wd[N-1:0];
    m_st = m_st | wr_bits;
    for (int i = 0; i < N; i++) begin
      m_ctl[i] = nctl[i];
      m_cnt[i] = ncnt[i];
    end
  endtask

  task automatic compare_all();
    chk("R5 ovf_o", W'(ovf), W'(|m_st));
    chk("R6 pmi_req_o", W'(pmi), W'(m_pmi));
    for (int a = 0; a < 10; a++) begin
      logic [W-1:0] e;
      string t;
      ra = 4'(a);
      #0.3;
      if (a < 4)       begin e = W'(m_ctl[a]);  t = "R2 ctl"; end
      else if (a < 8)  begin e = m_cnt[a-4];    t = "R3 cnt"; end
      else if (a == 8) begin e = W'(m_st);      t = "R5 status"; end
      else             begin e = '0;            t = "R7 clr_reads_zero"; end
      chk(t, rd, e);
    end
  endtask

  task automatic step(bit w, int adr, logic [W-1:0] d, logic [15:0] ev, bit fz);
    @(negedge clk);
    we = w; wa = 4'(adr); wd = d; evt = ev; frz = fz;
    @(posedge clk);
    model_edge();
    #0.5;
    compare_all();
  endtask

  task automatic run(int n, logic [15:0] ev, bit fz);
    for (int k = 0; k < n; k++) step(0, 0, '0, ev, fz);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evt = '0; frz = 0; we = 0; wa = '0; wd = '0; ra = '0;
    for (int i = 0; i < N; i++) begin m_ctl[i] = '0; m_cnt[i] = '0; end
    m_st = '0; m_pmi = 0;
    repeat (3) @(posedge clk);
    #1;
    compare_all();               // R1 reset state
    @(negedge clk); rst_n = 1;

    // R2 control setup: en/sel0, en+pmi/sel1, en/sel2, disabled/sel3
    step(1, 0, 48'h1, '0, 0);
    step(1, 1, 48'h7, '0, 0);
    step(1, 2, 48'h9, '0, 0);
    step(1, 3, 48'hC, '0, 0);
    // R3 varied event patterns
    for (int k = 0; k < 30; k++) step(0, 0, '0, 16'((k * 933) ^ (k << 5)), 0);
    // R4 alternating freeze with every event high
    for (int k = 0; k < 10; k++) step(0, 0, '0, 16'hFFFF, k[1]);
    // R5 R6 preload counter1 near wrap
    step(1, 5, ALL1 - 48'd2, 16'hFFFF, 0);
    run(5, 16'hFFFF, 0);
    // R6 second wrap with status already set: no pulse
    step(1, 5, ALL1 - 48'd1, 16'hFFFF, 0);
    run(4, 16'hFFFF, 0);
    // R10 write to status ignored
    step(1, 8, 48'hF, '0, 0);
    // R7 zero mask no effect, then clear bit1
    step(1, 9, 48'h0, '0, 0);
    step(1, 9, 48'h2, '0, 0);
    // R9 wrap of counter0 coincides with clear of bit0
    step(1, 4, ALL1, '0, 0);
    step(1, 9, 48'h1, 16'h0001, 0);
    run(2, '0, 0);
    step(1, 9, 48'h1, '0, 0);
    // R8 write beats increment, no overflow
    step(1, 6, ALL1, 16'h0400, 0);
    step(1, 6, ALL1, 16'h0400, 0);
    step(1, 6, 48'd5, 16'h0400, 0);
    // R4 frozen at all-ones: no wrap
    step(1, 6, ALL1, '0, 0);
    run(3, 16'hFFFF, 1);
    run(2, 16'hFFFF, 0);
    // R2 reselect counter2 to event 0 with pmi, counter3 enabled sel3
    step(1, 2, 48'h3, '0, 0);
    step(1, 7, ALL1 - 48'd1, '0, 0);
    step(1, 3, 48'hD, '0, 0);
    for (int k = 0; k < 12; k++) step(0, 0, '0, 16'((k * 4099) ^ 16'h8101), 0);
    step(1, 9, 48'hF, '0, 0);
    run(3, 16'hFFFF, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule